// File: doc/BRIEF.md
# DMA Channel Flag Command Registers

This block keeps two flag arrays, one flag per DMA channel. The start-request array marks channels that software asks to run. The completion array marks channels whose transfer has finished. Software changes the flags through two write-only command bytes on a 32-bit register bus. One byte raises start requests and the other lowers completion flags. Each byte holds an ignore bit and a 7-bit channel field. When the top bit of the field is set, the command acts on every channel at once. Otherwise it acts on the one channel the field names.

The ignore bit lets software write the whole word that holds both bytes and still leave a lane with no effect. A transfer-engine model drives one pulse per channel to report completion. The pulse raises that channel's completion flag and drops its start request. Both arrays are driven out as flat vectors to the descriptor logic nearby.

Top module: `dma_flag_cmd`

## Requirements
- R1: A synchronous active-high `rst` clears every start and done flag to 0 on the clock edge it is sampled.
- R2: A write to byte address 0x1C with `wr_be[1]` high acts on the set-start byte `wr_data[15:8]`. If bit 7 is 0 and bit 6 is 0, only the start flag of the channel in bits 5:0 (0 to 63) is set. All other flags keep their value.
- R3: In the same word, `wr_be[0]` high acts on the clear-done byte `wr_data[7:0]`. If bit 7 is 0 and bit 6 is 0, only the done flag of the channel in bits 5:0 is cleared.
- R4: If a command byte has bit 7 at 0 and bit 6 at 1 (channel field 64 to 127), the set-start byte sets all start flags and the clear-done byte clears all done flags.
- R5: A command byte with bit 7 at 1 changes no flag, whatever its other bits hold.
- R6: A byte lane whose enable is low changes no flag. `wr_be[3:2]` and `wr_data[31:16]` never affect the flags.
- R7: A write whose word address (`wr_addr[7:2]`) differs from that of 0x1C changes no flag.
- R8: When both lanes carry commands in one write, both take effect on the same clock edge.
- R9: A high bit of `eng_done` sets that channel's done flag and clears its start flag.
- R10: On the same channel in the same cycle, a clear-done command overrides an engine pulse for the done flag. A set-start command overrides it for the start flag.
- R11: A read strobe `rd_en` gives `rd_valid` high one cycle later, with `rd_data` all zeroes.
- R12: Flags change only on the clock edge that samples a command or pulse. They hold in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte address of the write, word aligned |
| wr_data | input | 32 | Write data, big-endian byte lanes |
| wr_be | input | 4 | Byte enables, bit n for `wr_data[8n+7:8n]` |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 32 | Read data, always zero |
| rd_valid | output | 1 | Read response, one cycle after `rd_en` |
| eng_done | input | 64 | Per-channel completion pulses from the engine |
| start_flags | output | 64 | Start-request flag per channel |
| done_flags | output | 64 | Completion flag per channel |

## Verification
Assertions check four things on every cycle. Ignored or disabled lanes produce empty masks. A single-channel command produces at most one mask bit. Commanded set and clear bits appear on the next edge. Foreign-address writes and idle cycles leave the arrays untouched. Other properties need the bench's scenarios: that the decoded channel is the right one, that the all-channels value reaches all 64 entries, and how the register commands and engine pulses combine when they meet on one channel.

// File: rtl/dma_cmd_pkg.sv
package dma_cmd_pkg;

    // Layout of one command byte; bit positions are decoded by the lane logic
    typedef struct packed {
        logic       nop;   // bit 7: ignore this byte
        logic       all;   // bit 6: act on every channel
        logic [5:0] ch;    // bits 5:0: channel index
    } cmd_byte_t;

    // Byte lanes of the command word (big-endian: 0x1E -> [15:8], 0x1F -> [7:0])
    localparam int LANE_SET_START = 1;
    localparam int LANE_CLR_DONE  = 0;

    typedef enum logic [0:0] {
        CMD_SET_START = 1'b0,
        CMD_CLR_DONE  = 1'b1
    } cmd_kind_e;

endpackage

// File: rtl/dma_cmd_lane.sv
module dma_cmd_lane
    import dma_cmd_pkg::*;
#(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  cmd_byte_t         cmd,
    output logic [NUM_CH-1:0] mask
);

    localparam int CH_W = $bits(cmd.ch);

    logic act;

    always_comb begin
        act  = hit && !cmd.nop;
        mask = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            mask[i] = act && (cmd.all || (cmd.ch == CH_W'(i)));
        end
    end

    AST_NOP_LANE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!hit || cmd.nop) |-> (mask == '0)); // R5

    AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
        (hit && !cmd.nop && !cmd.all) |-> $onehot0(mask)); // R2

endmodule

// File: rtl/dma_flag_bank.sv
module dma_flag_bank #(
    parameter int NUM_CH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] set_start,
    input  logic [NUM_CH-1:0] clr_done,
    input  logic [NUM_CH-1:0] eng_done,
    output logic [NUM_CH-1:0] start_q,
    output logic [NUM_CH-1:0] done_q
);

    typedef struct packed {
        logic [NUM_CH-1:0] start;
        logic [NUM_CH-1:0] done;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // engine completion first, register commands override it
        st_d.start = (st_q.start & ~eng_done) | set_start;
        st_d.done  = (st_q.done  |  eng_done) & ~clr_done;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start_q = st_q.start;
    assign done_q  = st_q.done;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (start_q == '0 && done_q == '0)); // R1

    AST_SET_LANDS: assert property (@(posedge clk) disable iff (rst)
        (set_start != '0) |=> ((start_q & $past(set_start)) == $past(set_start))); // R2

    AST_CLR_LANDS: assert property (@(posedge clk) disable iff (rst)
        (clr_done != '0) |=> ((done_q & $past(clr_done)) == '0)); // R10

    AST_ENGINE_DONE: assert property (@(posedge clk) disable iff (rst)
        (eng_done != '0) |=> ((done_q & $past(eng_done & ~clr_done))
                              == $past(eng_done & ~clr_done))); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (set_start == '0 && clr_done == '0 && eng_done == '0)
        |=> ($stable(start_q) && $stable(done_q))); // R12

endmodule

// File: rtl/dma_flag_cmd.sv
module dma_flag_cmd
    import dma_cmd_pkg::*;
#(
    parameter int          NUM_CH   = 64,
    parameter int          ADDR_W   = 8,
    parameter int          DATA_W   = 32,
    parameter logic [7:0]  CMD_WORD = 8'h1C
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic [NUM_CH-1:0] eng_done,
    output logic [NUM_CH-1:0] start_flags,
    output logic [NUM_CH-1:0] done_flags
);

    localparam int NUM_LANES = DATA_W / 8;
    localparam int WORD_LSB  = $clog2(NUM_LANES);

    logic              word_hit;
    logic [NUM_CH-1:0] lane_mask [2];
    logic              unused_bits;

    assign word_hit = wr_en && (wr_addr[ADDR_W-1:WORD_LSB] == CMD_WORD[ADDR_W-1:WORD_LSB]);

    for (genvar k = 0; k < 2; k++) begin : g_lane
        localparam int LANE = (k == int'(CMD_SET_START)) ? LANE_SET_START : LANE_CLR_DONE;
        dma_cmd_lane #(.NUM_CH(NUM_CH)) u_lane (
            .clk  (clk),
            .rst  (rst),
            .hit  (word_hit && wr_be[LANE]),
            .cmd  (cmd_byte_t'(wr_data[8*LANE +: 8])),
            .mask (lane_mask[k])
        );
    end

    assign unused_bits = ^{wr_addr[WORD_LSB-1:0], wr_data[DATA_W-1:16], wr_be[NUM_LANES-1:2]};

    dma_flag_bank #(.NUM_CH(NUM_CH)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .set_start (lane_mask[int'(CMD_SET_START)]),
        .clr_done  (lane_mask[int'(CMD_CLR_DONE)]),
        .eng_done  (eng_done),
        .start_q   (start_flags),
        .done_q    (done_flags)
    );

    // write-only registers: a read answers one cycle later with zero data
    typedef struct packed {
        logic rd_valid;
    } rd_state_t;

    rd_state_t rd_d, rd_q;

    always_comb begin
        rd_d.rd_valid = rd_en;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_valid = rd_q.rd_valid;
    assign rd_data  = '0;

    AST_FOREIGN_WORD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !word_hit && eng_done == '0)
        |=> ($stable(start_flags) && $stable(done_flags))); // R7

    AST_LANE_OFF: assert property (@(posedge clk) disable iff (rst)
        (wr_be[1:0] == 2'b00 && eng_done == '0)
        |=> ($stable(start_flags) && $stable(done_flags))); // R6

    AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid); // R11

endmodule

// File: tb/dma_flag_cmd_tb_top.sv
module dma_flag_cmd_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

    typedef struct packed {
        logic [7:0]  addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [63:0] eng;
        logic [63:0] exp_s;
        logic [63:0] exp_d;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{8'h1C, 4'b0010, 32'h0000_0500, 64'h0,   64'h20, 64'h0},
        '{8'h1C, 4'b0000, 32'h0000_0000, 64'h220, 64'h0,  64'h220},
        '{8'h1C, 4'b0001, 32'h0000_0009, 64'h0,   64'h0,  64'h20},
        '{8'h1C, 4'b0010, 32'h0000_4000, 64'h0,   ALL,    64'h20},
        '{8'h1C, 4'b0011, 32'h0000_8A8B, 64'h0,   ALL,    64'h20},
        '{8'h1C, 4'b1100, 32'h0000_0005, 64'h0,   ALL,    64'h20},
        '{8'h18, 4'b1111, 32'h0000_0005, 64'h0,   ALL,    64'h20},
        '{8'h1C, 4'b0000, 32'h0000_0000, ALL,     64'h0,  ALL},
        '{8'h1C, 4'b0011, 32'h0000_0307, 64'h0,   64'h8,  64'hFFFF_FFFF_FFFF_FF7F},
        '{8'h1C, 4'b0001, 32'h0000_007F, 64'h0,   64'h8,  64'h0},
        '{8'h1C, 4'b0011, 32'h0000_0402, 64'h14,  64'h18, 64'h10},
        '{8'h1C, 4'b1111, 32'hFFFF_8004, 64'h0,   64'h18, 64'h0}
    };
    localparam string TAG [NV] = '{"R2", "R9", "R3", "R4", "R5", "R6",
                                   "R7", "R9", "R8", "R4", "R10", "R5"};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_be = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [63:0] eng_done = '0;
    logic [63:0] start_flags, done_flags;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_flag_cmd dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .eng_done(eng_done), .start_flags(start_flags), .done_flags(done_flags)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // drive for one edge, then release and leave the bench at a falling edge
    task automatic step(input logic [7:0] a, input logic [3:0] be,
                        input logic [31:0] d, input logic [63:0] eng);
        @(negedge clk);
        wr_en = (be != 4'b0000); wr_addr = a; wr_be = be; wr_data = d; eng_done = eng;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0; wr_data = '0; eng_done = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "start after reset", start_flags, 64'h0);
        check("R1", "done after reset", done_flags, 64'h0);

        for (int v = 0; v < NV; v++) begin
            step(VEC[v].addr, VEC[v].be, VEC[v].data, VEC[v].eng);
            check(TAG[v], $sformatf("vec %0d start", v), start_flags, VEC[v].exp_s);
            check(TAG[v], $sformatf("vec %0d done", v), done_flags, VEC[v].exp_d);
        end

        // R12: idle cycles hold the flags
        repeat (3) @(negedge clk);
        check("R12", "idle start", start_flags, 64'h18);
        check("R12", "idle done", done_flags, 64'h0);

        // R2: highest single channel
        step(8'h1C, 4'b0010, 32'h0000_3F00, 64'h0);
        check("R2", "channel 63 start", start_flags, 64'h8000_0000_0000_0018);

        // R4: field value exactly 64 on clear lane, after the engine fills done
        step(8'h1C, 4'b0000, 32'h0, 64'h0000_0001_0000_0001);
        check("R9", "engine start drop", start_flags, 64'h8000_0000_0000_0018);
        step(8'h1C, 4'b0001, 32'h0000_0040, 64'h0);
        check("R4", "field 64 clears all", done_flags, 64'h0);

        // R11: read strobe answers next cycle with zero
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        check("R11", "read valid", {63'h0, rd_valid}, 64'h1);
        check("R11", "read data", {32'h0, rd_data}, 64'h0);
        @(negedge clk);
        check("R11", "read valid drop", {63'h0, rd_valid}, 64'h0);

        // R1: reset in mid run clears set flags
        step(8'h1C, 4'b0000, 32'h0, 64'h0F00);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", "mid-run reset start", start_flags, 64'h0);
        check("R1", "mid-run reset done", done_flags, 64'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule